// File: doc/BRIEF.md
# Two-Phase Register CPU

A compact 32-bit processor with eight general-purpose registers. It alternates strictly between two phases. In the fetch phase it reads an instruction word from memory at the program counter. In the execute phase it carries out that word. Memory sits on one shared bidirectional data bus, with a separate address output and a write strobe. The CPU lets go of the address and data lines whenever it is not moving data to or from memory, so other agents can share those wires.

Each instruction word holds a 7-bit operation code and three 3-bit register selects: a destination, a first source (Y) and a second source (X). It also holds a 16-bit immediate field, which serves as the memory address for load and store and as the jump target. The operations are no-op, load, store, and, or, xor, add, move, invert, jump and halt. Add feeds zero into the low carry and keeps the carry out of bit 31 as an overflow flag.

Top module: `simple_cpu`

## Requirements
- R1: Instruction fields are decoded from fixed positions: opcode [31:25], destination [24:22], source Y [21:19], source X [18:16], immediate [15:0]. The opcodes are no-op 0000000, load 1010100, store 1001100, and 0101000, or 0011000, xor 1011000, add 1100001, move 1000000, invert 0111111, jump 1111110 and halt 1111111.
- R2: In every fetch phase the address output equals the program counter and the write strobe is 0. The counter starts at 0 and advances by one after each fetch.
- R3: In the execute phase of a load, the address output is the immediate zero-extended to 32 bits, the strobe is 0, and the word read from the data bus is written into the destination register.
- R4: In the execute phase of a store, the address output is the zero-extended immediate, the strobe is 1, and the data bus carries source register Y. The strobe is never 1 in any other cycle.
- R5: In the execute phase of any instruction that does not touch memory (no-op, logic, add, move, invert, jump, halt), both the address output and the data bus are high impedance and the strobe is 0.
- R6: And, or and xor write Y op X into the destination. Move writes Y. Invert writes the bitwise complement of Y.
- R7: Add writes Y + X with a carry-in of 0. The overflow output takes the carry out of bit 31 one clock after the add's execute phase and keeps its value through all other instructions.
- R8: Jump loads the program counter with the zero-extended immediate, so the next fetch uses that address.
- R9: After a halt executes, the CPU never fetches again: the address and data lines stay released, the strobe stays 0, and the program counter holds.
- R10: Reset (asynchronous, active low) clears the program counter, the overflow flag and all eight registers, and returns the CPU to the fetch phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_o | output | 32 | Memory address. High impedance when no memory access is under way |
| data_io | inout | 32 | Shared data bus. Driven only during a store |
| rw_o | output | 1 | 1 while writing memory, 0 otherwise |
| ovf_o | output | 1 | Carry out of bit 31 from the most recent add |

## Verification
Address, strobe and data-bus values depend only on the current phase and the latched instruction, so the bench samples them at mid-cycle, once in the fetch phase and once in the execute phase of each instruction. The overflow flag and register writes land on the clock edge that ends an execute phase. For that reason the bench checks the flag at the following fetch. It observes register results only later, when a store puts them on the data bus and into the bench memory. Released lines are pulled high in the bench, so a released bus reads as all ones, and the program never uses an all-ones value or address where it expects a driven one.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 7;
  localparam int RSEL_W = 3;
  localparam int IMM_W  = 16;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP   = 7'b0000000,
    OPC_LOAD  = 7'b1010100,
    OPC_STORE = 7'b1001100,
    OPC_AND   = 7'b0101000,
    OPC_OR    = 7'b0011000,
    OPC_XOR   = 7'b1011000,
    OPC_ADD   = 7'b1100001,
    OPC_MOV   = 7'b1000000,
    OPC_NOT   = 7'b0111111,
    OPC_JMP   = 7'b1111110,
    OPC_HALT  = 7'b1111111
  } opc_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [RSEL_W-1:0] rd;
    logic [RSEL_W-1:0] ry;
    logic [RSEL_W-1:0] rx;
    logic [IMM_W-1:0]  imm;
  } insn_t;

  typedef enum logic [2:0] {
    ALU_AND, ALU_OR, ALU_XOR, ALU_ADD, ALU_PASS, ALU_INV
  } alu_op_e;

  typedef enum logic [1:0] {
    PH_FETCH, PH_EXEC, PH_HALT
  } phase_e;

  typedef struct packed {
    logic [RSEL_W-1:0] rd;
    logic [RSEL_W-1:0] ry;
    logic [RSEL_W-1:0] rx;
    logic [IMM_W-1:0]  imm;
    alu_op_e           alu;
    logic              reg_we;
    logic              is_load;
    logic              is_store;
    logic              is_jmp;
    logic              is_halt;
    logic              is_add;
  } ctl_t;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output ctl_t              ctl_o
);
  insn_t f;
  assign f = insn_t'(insn_i);

  always_comb begin
    ctl_o          = '0;
    ctl_o.rd       = f.rd;
    ctl_o.ry       = f.ry;
    ctl_o.rx       = f.rx;
    ctl_o.imm      = f.imm;
    ctl_o.alu      = ALU_PASS;
    case (f.opc)
      OPC_LOAD:  begin ctl_o.is_load = 1'b1; ctl_o.reg_we = 1'b1; end
      OPC_STORE: ctl_o.is_store = 1'b1;
      OPC_AND:   begin ctl_o.alu = ALU_AND; ctl_o.reg_we = 1'b1; end
      OPC_OR:    begin ctl_o.alu = ALU_OR;  ctl_o.reg_we = 1'b1; end
      OPC_XOR:   begin ctl_o.alu = ALU_XOR; ctl_o.reg_we = 1'b1; end
      OPC_ADD:   begin ctl_o.alu = ALU_ADD; ctl_o.reg_we = 1'b1; ctl_o.is_add = 1'b1; end
      OPC_MOV:   begin ctl_o.alu = ALU_PASS; ctl_o.reg_we = 1'b1; end
      OPC_NOT:   begin ctl_o.alu = ALU_INV; ctl_o.reg_we = 1'b1; end
      OPC_JMP:   ctl_o.is_jmp = 1'b1;
      OPC_HALT:  ctl_o.is_halt = 1'b1;
      default:   ;  // no-op and unassigned codes
    endcase
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic [W:0] sum;
  assign sum = {1'b0, y_i} + {1'b0, x_i};  // carry-in fixed at 0

  always_comb begin
    cout_o = 1'b0;
    case (op_i)
      ALU_AND: res_o = y_i & x_i;
      ALU_OR:  res_o = y_i | x_i;
      ALU_XOR: res_o = y_i ^ x_i;
      ALU_ADD: begin res_o = sum[W-1:0]; cout_o = sum[W]; end
      ALU_INV: res_o = ~y_i;
      default: res_o = y_i;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int N = 8,
  parameter int W = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ya_i,
  input  logic [AW-1:0] xa_i,
  output logic [W-1:0]  y_o,
  output logic [W-1:0]  x_o
);
  logic [W-1:0] regs [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        regs[g] <= '0;
        else if (we_i && wa_i == AW'(g))    regs[g] <= wd_i;
      end
    end
  endgenerate

  assign y_o = regs[ya_i];
  assign x_o = regs[xa_i];
endmodule

// File: rtl/simple_cpu.sv
module simple_cpu
  import cpu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int N_REGS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] addr_o,
  inout  wire  [DATA_W-1:0] data_io,
  output logic              rw_o,
  output logic              ovf_o
);
  localparam int PAD_W = ADDR_W - IMM_W;

  phase_e             phase_q;
  logic [ADDR_W-1:0]  pc_q;
  logic [INSN_W-1:0]  ir_q;
  ctl_t               ctl;
  logic [DATA_W-1:0]  y_val, x_val, alu_res, wr_data;
  logic               alu_cout;
  logic               in_fetch, in_exec, mem_op, reg_we;
  logic [ADDR_W-1:0]  imm_addr;
  logic [IMM_W-1:0]   imm_w;
  logic               dec_add, dec_jmp, dec_halt;

  cpu_decode u_dec (.insn_i(ir_q), .ctl_o(ctl));

  assign imm_w    = ctl.imm;
  assign dec_add  = ctl.is_add;
  assign dec_jmp  = ctl.is_jmp;
  assign dec_halt = ctl.is_halt;
  assign imm_addr = {{PAD_W{1'b0}}, imm_w};

  assign in_fetch = (phase_q == PH_FETCH);
  assign in_exec  = (phase_q == PH_EXEC);
  assign mem_op   = in_exec && (ctl.is_load || ctl.is_store);

  cpu_regfile #(.N(N_REGS), .W(DATA_W)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (reg_we),
    .wa_i  (ctl.rd),
    .wd_i  (wr_data),
    .ya_i  (ctl.ry),
    .xa_i  (ctl.rx),
    .y_o   (y_val),
    .x_o   (x_val)
  );

  cpu_alu #(.W(DATA_W)) u_alu (
    .op_i  (ctl.alu),
    .y_i   (y_val),
    .x_i   (x_val),
    .res_o (alu_res),
    .cout_o(alu_cout)
  );

  assign reg_we  = in_exec && ctl.reg_we;
  assign wr_data = ctl.is_load ? data_io : alu_res;

  // bus drivers: release everything outside memory transfers
  assign rw_o    = in_exec && ctl.is_store;
  assign addr_o  = in_fetch ? pc_q : (mem_op ? imm_addr : 'z);
  assign data_io = rw_o ? y_val : 'z;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      ovf_o   <= 1'b0;
    end else begin
      case (phase_q)
        PH_FETCH: begin
          ir_q    <= data_io[INSN_W-1:0];
          pc_q    <= pc_q + 1'b1;
          phase_q <= PH_EXEC;
        end
        PH_EXEC: begin
          if (dec_jmp) pc_q <= imm_addr;
          if (dec_add) ovf_o <= alu_cout;
          phase_q <= dec_halt ? PH_HALT : PH_FETCH;
        end
        default: phase_q <= PH_HALT;
      endcase
    end
  end
endmodule

// File: rtl/simple_cpu_chk.sv
module simple_cpu_chk
  import cpu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input phase_e            phase_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              add_i,
  input logic              jmp_i,
  input logic              halt_i,
  input logic              rw_i,
  input logic              ovf_i
);
  // R2: a fetch is followed by execute with the counter one higher
  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_FETCH) |=> (phase_i == PH_EXEC && pc_i == $past(pc_i) + 1'b1));

  // R4: strobe only in execute, with a zero-extended address
  a_r4_rw_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_i |-> (phase_i == PH_EXEC && addr_i[ADDR_W-1:IMM_W] == '0));

  // R5: non-halting execute returns to fetch
  a_r5_back_to_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_EXEC && !halt_i) |=> (phase_i == PH_FETCH));

  // R7: flag moves only after an add
  a_r7_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_i == PH_EXEC && add_i) |=> $stable(ovf_i));

  // R8: jump target lands in the counter
  a_r8_jmp_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_EXEC && jmp_i) |=> (pc_i == ADDR_W'($past(imm_i))));

  // R9: halted state is terminal and frozen
  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_HALT) |=> (phase_i == PH_HALT && $stable(pc_i) && !rw_i));
endmodule

bind simple_cpu simple_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .phase_i(phase_q),
  .pc_i   (pc_q),
  .addr_i (addr_o),
  .imm_i  (imm_w),
  .add_i  (dec_add),
  .jmp_i  (dec_jmp),
  .halt_i (dec_halt),
  .rw_i   (rw_o),
  .ovf_i  (ovf_o)
);

// File: tb/simple_cpu_tb_top.sv
module simple_cpu_tb_top;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [6:0] OP_NOP = 7'b0000000, OP_LD = 7'b1010100, OP_ST = 7'b1001100,
                         OP_AND = 7'b0101000, OP_OR = 7'b0011000, OP_XOR = 7'b1011000,
                         OP_ADD = 7'b1100001, OP_MOV = 7'b1000000, OP_NOT = 7'b0111111,
                         OP_JMP = 7'b1111110, OP_HLT = 7'b1111111;

  function automatic logic [31:0] enc(logic [6:0] op, logic [2:0] rd, logic [2:0] ry,
                                      logic [2:0] rx, logic [15:0] imm);
    return {op, rd, ry, rx, imm};
  endfunction

  typedef struct packed {
    logic [7:0]  pc;
    logic [31:0] insn;
    logic [31:0] ex_addr;
    logic        ex_rw;
    logic [31:0] ex_data;
    logic        ovf_after;
  } step_t;

  localparam int NSTEP = 23;
  localparam step_t STEPS [NSTEP] = '{
    '{8'd0,  enc(OP_LD, 3'd1,3'd0,3'd0,16'h30), 32'h30, 1'b0, 32'h0000_00F0, 1'b0},
    '{8'd1,  enc(OP_LD, 3'd2,3'd0,3'd0,16'h31), 32'h31, 1'b0, 32'h0F0F_0F3C, 1'b0},
    '{8'd2,  enc(OP_AND,3'd3,3'd1,3'd2,16'h0),  ONES,   1'b0, ONES,          1'b0},
    '{8'd3,  enc(OP_ST, 3'd0,3'd3,3'd0,16'h20), 32'h20, 1'b1, 32'h0000_0030, 1'b0},
    '{8'd4,  enc(OP_OR, 3'd3,3'd1,3'd2,16'h0),  ONES,   1'b0, ONES,          1'b0},
    '{8'd5,  enc(OP_ST, 3'd0,3'd3,3'd0,16'h21), 32'h21, 1'b1, 32'h0F0F_0FFC, 1'b0},
    '{8'd6,  enc(OP_XOR,3'd3,3'd1,3'd2,16'h0),  ONES,   1'b0, ONES,          1'b0},
    '{8'd7,  enc(OP_ST, 3'd0,3'd3,3'd0,16'h22), 32'h22, 1'b1, 32'h0F0F_0FCC, 1'b0},
    '{8'd8,  enc(OP_LD, 3'd5,3'd0,3'd0,16'h32), 32'h32, 1'b0, 32'h8000_0001, 1'b0},
    '{8'd9,  enc(OP_ADD,3'd6,3'd5,3'd5,16'h0),  ONES,   1'b0, ONES,          1'b1},
    '{8'd10, enc(OP_ST, 3'd0,3'd6,3'd0,16'h23), 32'h23, 1'b1, 32'h0000_0002, 1'b1},
    '{8'd11, enc(OP_ADD,3'd7,3'd1,3'd2,16'h0),  ONES,   1'b0, ONES,          1'b0},
    '{8'd12, enc(OP_ST, 3'd0,3'd7,3'd0,16'h24), 32'h24, 1'b1, 32'h0F0F_102C, 1'b0},
    '{8'd13, enc(OP_NOT,3'd4,3'd1,3'd0,16'h0),  ONES,   1'b0, ONES,          1'b0},
    '{8'd14, enc(OP_ST, 3'd0,3'd4,3'd0,16'h25), 32'h25, 1'b1, 32'hFFFF_FF0F, 1'b0},
    '{8'd15, enc(OP_MOV,3'd4,3'd2,3'd0,16'h0),  ONES,   1'b0, ONES,          1'b0},
    '{8'd16, enc(OP_ST, 3'd0,3'd4,3'd0,16'h26), 32'h26, 1'b1, 32'h0F0F_0F3C, 1'b0},
    '{8'd17, enc(OP_NOP,3'd0,3'd0,3'd0,16'h0),  ONES,   1'b0, ONES,          1'b0},
    '{8'd18, enc(OP_JMP,3'd0,3'd0,3'd0,16'h18), ONES,   1'b0, ONES,          1'b0},
    '{8'd24, enc(OP_ADD,3'd6,3'd5,3'd5,16'h0),  ONES,   1'b0, ONES,          1'b1},
    '{8'd25, enc(OP_LD, 3'd0,3'd0,3'd0,16'h20), 32'h20, 1'b0, 32'h0000_0030, 1'b1},
    '{8'd26, enc(OP_ST, 3'd0,3'd0,3'd0,16'h28), 32'h28, 1'b1, 32'h0000_0030, 1'b1},
    '{8'd27, enc(OP_HLT,3'd0,3'd0,3'd0,16'h0),  ONES,   1'b0, ONES,          1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  wire [31:0] addr_bus, data_bus;
  wire        rw_w, ovf_w;

  generate
    for (genvar b = 0; b < 32; b++) begin : g_pu
      pullup pu_a (addr_bus[b]);
      pullup pu_d (data_bus[b]);
    end
  endgenerate

  simple_cpu dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .addr_o (addr_bus),
    .data_io(data_bus),
    .rw_o   (rw_w),
    .ovf_o  (ovf_w)
  );

  // bench memory: answers reads on a driven address, captures writes
  logic [31:0] mem [64];
  logic        prog_we = 1'b0;
  logic [5:0]  prog_a  = '0;
  logic [31:0] prog_d  = '0;
  logic        rd_en;
  assign rd_en    = (rw_w === 1'b0) && (addr_bus !== ONES);
  assign data_bus = rd_en ? mem[addr_bus[5:0]] : 'z;

  always @(posedge clk) begin
    if (prog_we)            mem[prog_a] <= prog_d;
    else if (rw_w === 1'b1) mem[addr_bus[5:0]] <= data_bus;
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic prog(logic [5:0] a, logic [31:0] d);
    prog_a  = a;
    prog_d  = d;
    prog_we = 1'b1;
    @(posedge clk);
    #1 prog_we = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string ft;
    // R10: values held during reset
    #1;
    chk("R10 reset addr", addr_bus, 32'h0);
    chk("R10 reset rw", {31'd0, rw_w}, 32'd0);
    chk("R10 reset ovf", {31'd0, ovf_w}, 32'd0);

    for (int i = 0; i < NSTEP; i++) prog(6'(STEPS[i].pc), STEPS[i].insn);
    for (int t = 19; t < 24; t++) prog(6'(t), enc(OP_ST, 3'd0, 3'd1, 3'd0, 16'h3F));
    prog(6'h30, 32'h0000_00F0);
    prog(6'h31, 32'h0F0F_0F3C);
    prog(6'h32, 32'h8000_0001);

    @(negedge clk) rst_ni = 1'b1;
    #1;
    for (int i = 0; i < NSTEP; i++) begin
      ft = (int'(STEPS[i].pc) != i) ? "R8 jump fetch" : "R2 fetch";
      chk(ft, addr_bus, {24'd0, STEPS[i].pc});
      chk("R2 fetch rw", {31'd0, rw_w}, 32'd0);
      chk("R7 ovf", {31'd0, ovf_w}, {31'd0, (i == 0) ? 1'b0 : STEPS[i-1].ovf_after});
      @(negedge clk); #1;
      if (STEPS[i].ex_rw)               ft = "R1 R4 store";
      else if (STEPS[i].ex_addr == ONES) ft = "R1 R5 released";
      else                               ft = "R1 R3 load";
      chk({ft, " addr"}, addr_bus, STEPS[i].ex_addr);
      chk({ft, " rw"}, {31'd0, rw_w}, {31'd0, STEPS[i].ex_rw});
      chk({ft, " data"}, data_bus, STEPS[i].ex_data);
      @(negedge clk); #1;
    end

    // R9: nothing moves after halt
    for (int c = 0; c < 4; c++) begin
      chk("R9 halt addr", addr_bus, ONES);
      chk("R9 halt rw", {31'd0, rw_w}, 32'd0);
      chk("R9 halt data", data_bus, ONES);
      chk("R7 ovf held", {31'd0, ovf_w}, 32'd1);
      @(negedge clk); #1;
    end

    // results that reached memory through stores
    chk("R6 and", mem[6'h20], 32'h0000_0030);
    chk("R6 or", mem[6'h21], 32'h0F0F_0FFC);
    chk("R6 xor", mem[6'h22], 32'h0F0F_0FCC);
    chk("R7 add wrap", mem[6'h23], 32'h0000_0002);
    chk("R7 add", mem[6'h24], 32'h0F0F_102C);
    chk("R6 not", mem[6'h25], 32'hFFFF_FF0F);
    chk("R6 mov", mem[6'h26], 32'h0F0F_0F3C);
    chk("R3 load roundtrip", mem[6'h28], 32'h0000_0030);
    chk("R8 skipped words", mem[6'h3F], 32'hxxxx_xxxx);

    // R10: mid-run reset clears flag, counter and registers
    prog(6'h00, enc(OP_ST, 3'd0, 3'd7, 3'd0, 16'h3E));
    @(negedge clk) rst_ni = 1'b0;
    #1;
    chk("R10 async addr", addr_bus, 32'h0);
    chk("R10 async ovf", {31'd0, ovf_w}, 32'd0);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    chk("R10 restart fetch", addr_bus, 32'h0);
    @(negedge clk); #1;
    chk("R10 store addr", addr_bus, 32'h3E);
    chk("R10 store rw", {31'd0, rw_w}, 32'd1);
    chk("R10 cleared reg", data_bus, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule